// File: doc/BRIEF.md
# Packed Horizontal Pair Adder

This unit is a SIMD datapath stage that sums neighbouring elements inside each of two source vectors and packs the sums into one destination vector. Each result element is the wrap-around sum of source elements 2i+1 and 2i. The sums of the first source fill the lower part of the result and the sums of the second source fill the upper part. Elements are 16 or 32 bits wide. The operation runs on a 64-bit, 128-bit or 256-bit vector. In 256-bit mode each 128-bit lane is handled on its own, with both sources split along the same lane boundary.

The result is registered and appears one clock after the request. Bits of the destination that the operation does not write come from the caller's old destination value. In 64-bit mode they are always kept. In 128-bit mode a policy input either keeps them or clears them. For the two-operand form, where the destination is also the first source, the caller drives the old destination onto `src_a_i`.

Two fault flags are provided. An illegal width code sets one flag. A misaligned memory operand in 128-bit mode sets the other. Either fault suppresses the result, so the registered result keeps its previous value. Instruction fetch, prefix decode and register-file access are outside this unit.

Top module: `hpair_add_unit`

## Requirements
- R1: `out_valid_o` is high for exactly one cycle, one clock after an accepted request on `in_valid_i`. It stays low in cycles with no request. Reset clears `out_valid_o`, both fault flags and `result_o`.
- R2: With `elem32_i`=0 (16-bit elements), result element i is source element 2i+1 plus source element 2i, modulo 2^16. No overflow or carry indication is produced, so 0x7FFF+0x0001 gives 0x8000 and 0xFFFF+0xFFFF gives 0xFFFE.
- R3: With `elem32_i`=1 (32-bit elements), result element i is source element 2i+1 plus source element 2i, modulo 2^32. For example, 0xFFFFFFFF+0x00000001 gives 0.
- R4: With `width_i`=1 (128-bit mode), result bits 63:0 hold the pair sums of `src_a_i[127:0]` in order, and bits 127:64 hold the pair sums of `src_b_i[127:0]` in order.
- R5: With `width_i`=0 (64-bit mode), result bits 31:0 hold the pair sums of `src_a_i[63:0]`, bits 63:32 hold those of `src_b_i[63:0]`, and bits 255:64 equal `dest_hi_i`, which carries the old destination bits 255:64.
- R6: With `width_i`=2 (256-bit mode), the low lane (bits 127:0) is formed as in R4. In the high lane, bits 191:128 hold the pair sums of `src_a_i[255:128]` and bits 255:192 hold those of `src_b_i[255:128]`.
- R7: In 128-bit mode, `zero_upper_i`=1 clears result bits 255:128. With `zero_upper_i`=0 those bits equal old destination bits 255:128, carried on `dest_hi_i[191:64]`.
- R8: A request with `width_i`=3 sets `illegal_o` for one cycle, one clock later. `out_valid_o` stays low and `result_o` keeps its previous value.
- R9: A 128-bit request with `b_from_mem_i`=1 and `b_addr_lo_i`≠0 sets `align_fault_o` for one cycle, one clock later. `out_valid_o` stays low and `result_o` keeps its previous value. An aligned address, a register operand (`b_from_mem_i`=0) and the 64-bit and 256-bit modes raise no alignment fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Request strobe |
| elem32_i | input | 1 | Element size: 0 selects 16-bit, 1 selects 32-bit |
| width_i | input | 2 | Vector width: 0 = 64, 1 = 128, 2 = 256, 3 = illegal |
| zero_upper_i | input | 1 | 128-bit mode only: 1 clears bits 255:128, 0 keeps them |
| src_a_i | input | 256 | First source vector |
| src_b_i | input | 256 | Second source vector |
| dest_hi_i | input | 192 | Old destination bits 255:64 |
| b_from_mem_i | input | 1 | Second source was read from memory |
| b_addr_lo_i | input | 4 | Low address bits of the memory operand |
| result_o | output | 256 | Registered packed result |
| out_valid_o | output | 1 | Result is valid in this cycle |
| illegal_o | output | 1 | Previous request had an illegal width code |
| align_fault_o | output | 1 | Previous request had a misaligned memory operand |

## Verification
Every outcome of a request is due exactly one rising edge after the request is presented: the packed result with `out_valid_o`, or one of the two fault flags with the result held. The driver changes inputs on the falling edge and pushes exactly one expected record per cycle, including a hold record for an idle cycle. Because of this, the position of a record in the queue equals its due cycle. The monitor pops one record shortly after each rising edge and compares all four outputs. Because the held result is also modelled, a fault or idle cycle that changes `result_o` is caught at the cycle where it happens.

// File: rtl/hpair_pkg.sv
package hpair_pkg;
  typedef enum logic [1:0] {
    WID_64  = 2'd0,
    WID_128 = 2'd1,
    WID_256 = 2'd2,
    WID_BAD = 2'd3
  } width_e;

  localparam int unsigned ALIGN_BYTES = 16;
  localparam int unsigned ALIGN_W     = $clog2(ALIGN_BYTES);
endpackage

// File: rtl/hpair_pack.sv
// Pair sums of one lane: element i = elem(2i+1) + elem(2i), wrap-around.
module hpair_pack #(
  parameter int unsigned IN_W = 128
) (
  input  logic [IN_W-1:0]   vec_i,
  input  logic              elem32_i,
  output logic [IN_W/2-1:0] sum_o
);
  localparam int unsigned N16 = IN_W / 32;
  localparam int unsigned N32 = IN_W / 64;

  logic [IN_W/2-1:0] s16;
  logic [IN_W/2-1:0] s32;

  for (genvar i = 0; i < N16; i++) begin : g_w16
    assign s16[16*i +: 16] = vec_i[32*i+16 +: 16] + vec_i[32*i +: 16];
  end

  for (genvar i = 0; i < N32; i++) begin : g_w32
    assign s32[32*i +: 32] = vec_i[64*i+32 +: 32] + vec_i[64*i +: 32];
  end

  assign sum_o = elem32_i ? s32 : s16;
endmodule

// File: rtl/hpair_fault.sv
module hpair_fault
  import hpair_pkg::*;
(
  input  logic               in_valid_i,
  input  width_e             width_i,
  input  logic               b_from_mem_i,
  input  logic [ALIGN_W-1:0] b_addr_lo_i,
  output logic               illegal_o,
  output logic               misalign_o,
  output logic               accept_o
);
  always_comb begin
    illegal_o  = in_valid_i && (width_i == WID_BAD);
    misalign_o = in_valid_i && (width_i == WID_128) && b_from_mem_i && (|b_addr_lo_i);
    accept_o   = in_valid_i && !illegal_o && !misalign_o;
  end
endmodule

// File: rtl/hpair_select.sv
// Places lane sums by width mode and applies the upper-bits policy.
module hpair_select
  import hpair_pkg::*;
#(
  parameter int unsigned VEC_W  = 256,
  parameter int unsigned LANE_W = 128
) (
  input  width_e                   width_i,
  input  logic                     zero_upper_i,
  input  logic [VEC_W/2-1:0]       sum_a_i,
  input  logic [VEC_W/2-1:0]       sum_b_i,
  input  logic [VEC_W-LANE_W/2-1:0] dest_hi_i,
  output logic [VEC_W-1:0]         res_o
);
  localparam int unsigned HALF      = LANE_W / 2;
  localparam int unsigned QW        = LANE_W / 4;
  localparam int unsigned NUM_LANES = VEC_W / LANE_W;

  always_comb begin
    res_o = '0;
    unique case (width_i)
      WID_64: res_o = {dest_hi_i, sum_b_i[QW-1:0], sum_a_i[QW-1:0]};
      WID_128: begin
        res_o[LANE_W-1:0] = {sum_b_i[HALF-1:0], sum_a_i[HALF-1:0]};
        if (!zero_upper_i) res_o[VEC_W-1:LANE_W] = dest_hi_i[VEC_W-HALF-1:LANE_W-HALF];
      end
      WID_256: begin
        for (int l = 0; l < NUM_LANES; l++) begin
          res_o[LANE_W*l +: LANE_W] = {sum_b_i[HALF*l +: HALF], sum_a_i[HALF*l +: HALF]};
        end
      end
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/hpair_add_unit.sv
module hpair_add_unit
  import hpair_pkg::*;
#(
  parameter int unsigned VEC_W  = 256,
  parameter int unsigned LANE_W = 128
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      in_valid_i,
  input  logic                      elem32_i,
  input  logic [1:0]                width_i,
  input  logic                      zero_upper_i,
  input  logic [VEC_W-1:0]          src_a_i,
  input  logic [VEC_W-1:0]          src_b_i,
  input  logic [VEC_W-LANE_W/2-1:0] dest_hi_i,
  input  logic                      b_from_mem_i,
  input  logic [ALIGN_W-1:0]        b_addr_lo_i,
  output logic [VEC_W-1:0]          result_o,
  output logic                      out_valid_o,
  output logic                      illegal_o,
  output logic                      align_fault_o
);
  localparam int unsigned HALF      = LANE_W / 2;
  localparam int unsigned NUM_LANES = VEC_W / LANE_W;

  width_e            wsel;
  logic [VEC_W/2-1:0] sum_a;
  logic [VEC_W/2-1:0] sum_b;
  logic [VEC_W-1:0]   res_d;
  logic               ill_d;
  logic               mis_d;
  logic               acc_d;

  assign wsel = width_e'(width_i);

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    hpair_pack #(.IN_W(LANE_W)) u_pack_a (
      .vec_i   (src_a_i[LANE_W*l +: LANE_W]),
      .elem32_i(elem32_i),
      .sum_o   (sum_a[HALF*l +: HALF])
    );
    hpair_pack #(.IN_W(LANE_W)) u_pack_b (
      .vec_i   (src_b_i[LANE_W*l +: LANE_W]),
      .elem32_i(elem32_i),
      .sum_o   (sum_b[HALF*l +: HALF])
    );
  end

  hpair_select #(.VEC_W(VEC_W), .LANE_W(LANE_W)) u_select (
    .width_i     (wsel),
    .zero_upper_i(zero_upper_i),
    .sum_a_i     (sum_a),
    .sum_b_i     (sum_b),
    .dest_hi_i   (dest_hi_i),
    .res_o       (res_d)
  );

  hpair_fault u_fault (
    .in_valid_i  (in_valid_i),
    .width_i     (wsel),
    .b_from_mem_i(b_from_mem_i),
    .b_addr_lo_i (b_addr_lo_i),
    .illegal_o   (ill_d),
    .misalign_o  (mis_d),
    .accept_o    (acc_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o      <= '0;
      out_valid_o   <= 1'b0;
      illegal_o     <= 1'b0;
      align_fault_o <= 1'b0;
    end else begin
      if (acc_d) result_o <= res_d;
      out_valid_o   <= acc_d;
      illegal_o     <= ill_d;
      align_fault_o <= mis_d;
    end
  end

  // R1
  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o && !illegal_o && !align_fault_o);
  a_r1_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && width_i != 2'd3 && !(width_i == 2'd1 && b_from_mem_i && b_addr_lo_i != '0)
    |=> out_valid_o);
  a_r5_keep_upper: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && width_i == 2'd0 |=> result_o[VEC_W-1:HALF] == $past(dest_hi_i));
  a_r7_zero_upper: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && width_i == 2'd1 && zero_upper_i && !(b_from_mem_i && b_addr_lo_i != '0)
    |=> result_o[VEC_W-1:LANE_W] == '0);
  a_r8_illegal_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && width_i == 2'd3 |=> illegal_o && !out_valid_o && $stable(result_o));
  a_r9_misalign_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && width_i == 2'd1 && b_from_mem_i && b_addr_lo_i != '0
    |=> align_fault_o && !out_valid_o && $stable(result_o));
  a_r9_flags_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({out_valid_o, illegal_o, align_fault_o}) <= 1);
endmodule

// File: tb/hpair_add_unit_tb_top.sv
`timescale 1ns/1ps
module hpair_add_unit_tb_top;
  typedef struct {
    logic         vld;
    logic         ill;
    logic         mis;
    logic [255:0] res;
    string        req;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         elem32 = 1'b0;
  logic [1:0]   width = 2'd0;
  logic         zero_upper = 1'b0;
  logic [255:0] src_a = '0;
  logic [255:0] src_b = '0;
  logic [191:0] dest_hi = '0;
  logic         b_mem = 1'b0;
  logic [3:0]   b_addr = '0;
  logic [255:0] result;
  logic         out_valid, illegal, align_fault;

  int checks = 0;
  int errors = 0;
  exp_t q[$];
  logic [255:0] held = '0;

  always #4 clk = ~clk;

  hpair_add_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .elem32_i(elem32),
    .width_i(width), .zero_upper_i(zero_upper), .src_a_i(src_a), .src_b_i(src_b),
    .dest_hi_i(dest_hi), .b_from_mem_i(b_mem), .b_addr_lo_i(b_addr),
    .result_o(result), .out_valid_o(out_valid), .illegal_o(illegal),
    .align_fault_o(align_fault)
  );

  function automatic logic [63:0] pairs(input logic [127:0] v, input logic e32);
    logic [63:0] r = '0;
    if (e32) begin
      for (int k = 0; k < 2; k++) r[32*k +: 32] = v[64*k +: 32] + v[64*k+32 +: 32];
    end else begin
      for (int k = 0; k < 4; k++) r[16*k +: 16] = v[32*k +: 16] + v[32*k+16 +: 16];
    end
    return r;
  endfunction

  function automatic logic [255:0] model(input logic e32, input logic [1:0] w, input logic zu,
                                         input logic [255:0] a, input logic [255:0] b,
                                         input logic [191:0] dh);
    logic [255:0] r = '0;
    logic [63:0] pa = pairs(a[127:0], e32);
    logic [63:0] pb = pairs(b[127:0], e32);
    case (w)
      2'd0: r = {dh, pb[31:0], pa[31:0]};
      2'd1: r = {(zu ? 128'd0 : dh[191:64]), pb, pa};
      default: r = {pairs(b[255:128], e32), pairs(a[255:128], e32), pb, pa};
    endcase
    return r;
  endfunction

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic op(input logic e32, input logic [1:0] w, input logic zu,
                    input logic [255:0] a, input logic [255:0] b, input logic [191:0] dh,
                    input logic mem, input logic [3:0] addr, input string req);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1; elem32 = e32; width = w; zero_upper = zu;
    src_a = a; src_b = b; dest_hi = dh; b_mem = mem; b_addr = addr;
    e.vld = 1'b0; e.ill = 1'b0; e.mis = 1'b0; e.req = req;
    if (w == 2'd3) e.ill = 1'b1;
    else if (w == 2'd1 && mem && addr != 4'd0) e.mis = 1'b1;
    else begin
      e.vld = 1'b1;
      held = model(e32, w, zu, a, b, dh);
    end
    e.res = held;
    q.push_back(e);
  endtask

  task automatic idle(input string req);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b0;
    src_a = {8{$urandom}}; dest_hi = {6{$urandom}};
    e.vld = 1'b0; e.ill = 1'b0; e.mis = 1'b0; e.res = held; e.req = req;
    q.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        e = q.pop_front();
        chk(out_valid == e.vld, e.req, "out_valid", {255'd0, out_valid}, {255'd0, e.vld});
        chk(illegal == e.ill, e.req, "illegal", {255'd0, illegal}, {255'd0, e.ill});
        chk(align_fault == e.mis, e.req, "align_fault", {255'd0, align_fault}, {255'd0, e.mis});
        chk(result == e.res, e.req, "result", result, e.res);
      end
    end
  end

  initial begin : watchdog
    #(8 * 100000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : driver
    logic [255:0] ra, rb;
    logic [191:0] rd;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(out_valid == 1'b0, "R1", "reset out_valid", {255'd0, out_valid}, '0);
    chk(illegal == 1'b0 && align_fault == 1'b0, "R1", "reset flags",
        {254'd0, illegal, align_fault}, '0);
    chk(result == '0, "R1", "reset result", result, '0);
    rst_n = 1'b1;
    idle("R1");

    // R2 R4 16-bit wrap pairs, R7 zero policy
    op(1'b0, 2'd1, 1'b1, {128'd0, 16'h0005, 16'h0004, 16'h0003, 16'h0002, 16'hFFFF, 16'hFFFF, 16'h0001, 16'h7FFF},
       {128'd0, 16'h1000, 16'h0001, 16'h8000, 16'h8000, 16'h0000, 16'h1234, 16'hFFFF, 16'h0001},
       {6{32'hA5A5_5A5A}}, 1'b0, 4'd0, "R2");
    // R3 32-bit wrap, R7 keep policy
    op(1'b1, 2'd1, 1'b0, {128'd0, 32'h0000_0002, 32'h0000_0003, 32'h0000_0001, 32'hFFFF_FFFF},
       {128'd0, 32'h7FFF_FFFF, 32'h0000_0001, 32'h1234_5678, 32'h1111_1111},
       {6{32'hDEAD_BEEF}}, 1'b0, 4'd0, "R7");
    idle("R1");
    for (int n = 0; n < 6; n++) begin
      ra = {8{$urandom}}; rb = {8{$urandom}}; rd = {6{$urandom}};
      op(n[0], 2'd1, n[1], ra, rb, rd, n[2], 4'd0, "R4");
      op(n[0], 2'd0, 1'b1, ra, rb, rd, 1'b0, 4'd0, "R5");
      op(n[0], 2'd2, 1'b0, ra, rb, rd, 1'b1, 4'd4, "R6");
    end
    // R8 illegal width keeps result
    op(1'b0, 2'd3, 1'b1, {8{32'h1111_2222}}, {8{32'h3333_4444}}, '0, 1'b0, 4'd0, "R8");
    idle("R8");
    // R9 misaligned memory operand
    op(1'b1, 2'd1, 1'b1, {8{32'h0F0F_0F0F}}, {8{32'h1}}, '0, 1'b1, 4'd8, "R9");
    op(1'b1, 2'd1, 1'b1, {8{32'h0F0F_0F0F}}, {8{32'h1}}, '0, 1'b1, 4'd1, "R9");
    op(1'b1, 2'd1, 1'b1, {8{32'h0F0F_0F0F}}, {8{32'h1}}, '0, 1'b0, 4'd7, "R9");
    op(1'b0, 2'd0, 1'b0, {8{32'h0F0F_0F0F}}, {8{32'h2}}, {6{32'h77}}, 1'b1, 4'd3, "R9");
    op(1'b0, 2'd1, 1'b0, {8{32'h0F0F_0F0F}}, {8{32'h2}}, {6{32'h77}}, 1'b1, 4'd0, "R9");
    // R6 high-lane 32-bit wrap
    op(1'b1, 2'd2, 1'b1, {32'h1, 32'hFFFF_FFFF, 64'd5, 128'd0}, {32'h8000_0000, 32'h8000_0000, 64'd9, 128'd0},
       '0, 1'b0, 4'd0, "R6");
    idle("R1");
    idle("R1");
    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule